// File: doc/BRIEF.md
# Angle Sensor Health Supervisor

This block sits on the host side of a magnetic rotary angle sensor and turns the sensor's failure signatures into clean fault flags. It takes in the two active-low magnet-range lines, the pulse-width output, and the A, B and Index incremental lines. All of these are asynchronous, so each passes through a two-stage synchronizer first. It also takes the status word of each received serial position frame, which arrives already aligned to the system clock together with a one-cycle strobe.

Level conditions on the magnet lines and the incremental lines must persist for a set number of consecutive clocks before they are reported, which rejects short glitches. A watchdog declares that the sensor supply is lost when the pulse-width output stops. While that timeout is active, both magnet lines reading low is put down to the missing supply and not to a field error. The two serial-frame flags are sticky and stay set until the host pulses a clear input. A single summary output is the OR of the six fault flags.

Top module: `enc_health_mon`

## Requirements
- R1: Each asynchronous input passes through two flops, and a level condition is reported only after it has held for QUAL_LEN consecutive clocks. A condition that lasts QUAL_LEN-1 clocks is never reported. A reported condition drops within three clocks of its input going away.
- R2: `flt_field` is high when both `mag_inc_n` and `mag_dec_n` are qualified low and the pulse watchdog has not timed out.
- R3: `mag_near` is high when only `mag_inc_n` is qualified low. `mag_far` is high when only `mag_dec_n` is qualified low. The two are never high together.
- R4: `flt_power` goes high once PWM_TIMEOUT clocks pass with no synchronized rising edge on `pwm_in`. The default of 100000 clocks is 2 ms at 50 MHz. Any rising edge clears it.
- R5: While `flt_power` is high, both magnet lines reading low does not set `flt_field`.
- R6: On a clock with `frm_stb` high, a status word whose bit OCF_BIT (the compensation-finished bit) is 0 sets the sticky `flt_frame`. A valid frame does not clear it.
- R7: On a clock with `frm_stb` high, a frame whose data word and status word are both all zero sets the sticky `flt_zero`.
- R8: A `frm_clr` pulse clears `flt_frame` and `flt_zero` on the next edge. If a strobe in the same clock carries a new failing frame, that flag stays set.
- R9: `flt_startup` is high while A, B and Index are qualified high together.
- R10: `flt_index` is high while Index is qualified high together with A or B, but not with both of them.
- R11: `fault` equals the OR of `flt_field`, `flt_power`, `flt_frame`, `flt_zero`, `flt_startup` and `flt_index`. The two direction outputs do not feed it.
- R12: A synchronous active-low `rst_n` clears every flag, qualifier and watchdog count, and all outputs read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mag_inc_n | input | 1 | Magnet-range line, low when field rises (async) |
| mag_dec_n | input | 1 | Magnet-range line, low when field falls (async) |
| pwm_in | input | 1 | Sensor pulse-width output (async) |
| inc_a | input | 1 | Incremental A (async) |
| inc_b | input | 1 | Incremental B (async) |
| inc_idx | input | 1 | Incremental Index (async) |
| frm_stb | input | 1 | One-cycle strobe for a received frame |
| frm_data | input | DATA_W | Frame position word |
| frm_stat | input | STAT_W | Frame status bits, bit OCF_BIT = compensation finished |
| frm_clr | input | 1 | Clears the sticky frame flags |
| fault | output | 1 | Any fault flag set |
| flt_field | output | 1 | Magnet field out of range |
| flt_power | output | 1 | Pulse output missing (supply loss) |
| flt_frame | output | 1 | Sticky: frame without compensation-finished bit |
| flt_zero | output | 1 | Sticky: all-zero frame |
| flt_startup | output | 1 | A, B, Index all high |
| flt_index | output | 1 | Index high with only one of A, B |
| mag_near | output | 1 | Magnet approaching |
| mag_far | output | 1 | Magnet receding |

## Verification
All eight A/B/Index combinations are crossed with all four magnet-line combinations while pulses are running, so each output is separated from its neighbours: near from far, field error from the direction indications, startup from index error. The same magnet patterns are then repeated with the pulse train stopped, which separates supply loss from a field error. Every combination of status bits is strobed with zero and non-zero data words, which separates an invalid frame from an all-zero frame. Glitches of QUAL_LEN-1 and QUAL_LEN clocks mark the qualification boundary, and a clear given together with a strobe shows which of the two takes precedence.

// File: rtl/enc_health_pkg.sv
// Shared constants for the angle sensor health supervisor.
// Assumes: condition vector indices are used consistently by the top.
package enc_health_pkg;
    localparam int NCOND    = 5;
    localparam int C_BOTHLO = 0;   // both magnet lines low
    localparam int C_INCLO  = 1;   // only increase-side low
    localparam int C_DECLO  = 2;   // only decrease-side low
    localparam int C_ALLHI  = 3;   // A, B, Index all high
    localparam int C_IDXBAD = 4;   // Index with exactly one of A/B
endpackage

// File: rtl/ehm_sync2.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; RST_VAL gives the idle level per bit.
module ehm_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then re-register every input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ehm_qual.sv
// Consecutive-clock qualifier: q rises once cond has been true for LEN
// clocks in a row, and falls one clock after cond goes false.
// Assumes: LEN >= 1; cond is synchronous to clk.
module ehm_qual #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic q
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] run_cnt;

    // Count consecutive true cycles, saturating at LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_cnt <= '0;
        else if (!cond)                run_cnt <= '0;
        else if (run_cnt != CW'(LEN))  run_cnt <= run_cnt + 1'b1;
    end

    assign q = (run_cnt == CW'(LEN));

    // R1
    qual_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q |-> $past(cond));
endmodule

// File: rtl/ehm_pwm_wd.sv
// Pulse watchdog: counts clocks since the last rising edge of a
// synchronized pulse train and flags a timeout at LIMIT.
// Assumes: pwm is already synchronized to clk.
module ehm_pwm_wd #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] idle_cnt;
    logic          pwm_d;
    logic          rise;

    assign rise = pwm & ~pwm_d;

    // Remember previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_d <= 1'b0;
        else        pwm_d <= pwm;
    end

    // Idle counter: restart on each rising edge, saturate at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                      idle_cnt <= '0;
        else if (rise)                   idle_cnt <= '0;
        else if (idle_cnt != CW'(LIMIT)) idle_cnt <= idle_cnt + 1'b1;
    end

    assign timeout = (idle_cnt == CW'(LIMIT));

    // R4
    edge_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !timeout);
endmodule

// File: rtl/enc_health_mon.sv
// Angle sensor health supervisor: synchronizes sensor status lines,
// qualifies level conditions, watches the pulse output and checks
// received frames, then reports per-fault flags and a summary.
// Assumes: frm_* inputs are synchronous to clk; others are asynchronous.
module enc_health_mon
    import enc_health_pkg::*;
#(
    parameter int QUAL_LEN    = 4,
    parameter int PWM_TIMEOUT = 100000,
    parameter int DATA_W      = 12,
    parameter int STAT_W      = 6,
    parameter int OCF_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mag_inc_n,
    input  logic              mag_dec_n,
    input  logic              pwm_in,
    input  logic              inc_a,
    input  logic              inc_b,
    input  logic              inc_idx,
    input  logic              frm_stb,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [STAT_W-1:0] frm_stat,
    input  logic              frm_clr,
    output logic              fault,
    output logic              flt_field,
    output logic              flt_power,
    output logic              flt_frame,
    output logic              flt_zero,
    output logic              flt_startup,
    output logic              flt_index,
    output logic              mag_near,
    output logic              mag_far
);
    localparam int NIN = 6;
    localparam logic [NIN-1:0] IDLE = 6'b110000;

    logic [NIN-1:0]   raw_in, sy;
    logic             s_inc_n, s_dec_n, s_pwm, s_a, s_b, s_i;
    logic [NCOND-1:0] cond, qual;
    logic             pwm_to;

    assign raw_in = {mag_inc_n, mag_dec_n, pwm_in, inc_a, inc_b, inc_idx};

    ehm_sync2 #(.W(NIN), .RST_VAL(IDLE)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sy));

    assign {s_inc_n, s_dec_n, s_pwm, s_a, s_b, s_i} = sy;

    // Raw level conditions from the synchronized lines.
    always_comb begin
        cond           = '0;
        cond[C_BOTHLO] = ~s_inc_n & ~s_dec_n;
        cond[C_INCLO]  = ~s_inc_n &  s_dec_n;
        cond[C_DECLO]  =  s_inc_n & ~s_dec_n;
        cond[C_ALLHI]  =  s_a & s_b & s_i;
        cond[C_IDXBAD] =  s_i & (s_a ^ s_b);
    end

    for (genvar g = 0; g < NCOND; g++) begin : g_qual
        ehm_qual #(.LEN(QUAL_LEN)) qual_i (
            .clk(clk), .rst_n(rst_n), .cond(cond[g]), .q(qual[g]));
    end

    ehm_pwm_wd #(.LIMIT(PWM_TIMEOUT)) wd_i (
        .clk(clk), .rst_n(rst_n), .pwm(s_pwm), .timeout(pwm_to));

    // Sticky frame checks: a new failing frame wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_frame <= 1'b0;
            flt_zero  <= 1'b0;
        end else begin
            flt_frame <= (flt_frame & ~frm_clr) | (frm_stb & ~frm_stat[OCF_BIT]);
            flt_zero  <= (flt_zero  & ~frm_clr) |
                         (frm_stb & (frm_data == '0) & (frm_stat == '0));
        end
    end

    assign flt_power   = pwm_to;
    assign flt_field   = qual[C_BOTHLO] & ~pwm_to;
    assign mag_near    = qual[C_INCLO];
    assign mag_far     = qual[C_DECLO];
    assign flt_startup = qual[C_ALLHI];
    assign flt_index   = qual[C_IDXBAD];
    assign fault       = flt_field | flt_power | flt_frame | flt_zero |
                         flt_startup | flt_index;

    // R5
    field_vs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_field && flt_power));

    // R3
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mag_near && mag_far));

    // R10
    idx_vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_index && flt_startup));

    // R6
    frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && !frm_stat[OCF_BIT]) |=> flt_frame);

    // R8
    frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_clr && !frm_stb) |=> (!flt_frame && !flt_zero));
endmodule

// File: tb/enc_health_mon_tb.sv
module enc_health_mon_tb_top;
    localparam int QL = 3;
    localparam int TO = 64;
    localparam int DW = 8;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mag_inc_n = 1'b1, mag_dec_n = 1'b1, pwm_in = 1'b0;
    logic inc_a = 1'b0, inc_b = 1'b0, inc_idx = 1'b0;
    logic frm_stb = 1'b0, frm_clr = 1'b0;
    logic [DW-1:0] frm_data = '0;
    logic [SW-1:0] frm_stat = '0;
    logic fault, flt_field, flt_power, flt_frame, flt_zero;
    logic flt_startup, flt_index, mag_near, mag_far;
    logic pwm_en = 1'b0;
    int   pcnt = 0;
    int   n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    enc_health_mon #(.QUAL_LEN(QL), .PWM_TIMEOUT(TO), .DATA_W(DW),
                     .STAT_W(SW), .OCF_BIT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mag_inc_n(mag_inc_n), .mag_dec_n(mag_dec_n),
        .pwm_in(pwm_in), .inc_a(inc_a), .inc_b(inc_b), .inc_idx(inc_idx),
        .frm_stb(frm_stb), .frm_data(frm_data), .frm_stat(frm_stat),
        .frm_clr(frm_clr), .fault(fault), .flt_field(flt_field),
        .flt_power(flt_power), .flt_frame(flt_frame), .flt_zero(flt_zero),
        .flt_startup(flt_startup), .flt_index(flt_index),
        .mag_near(mag_near), .mag_far(mag_far));

    // Pulse train: period 20 clocks, well inside the timeout.
    always @(negedge clk) begin
        pcnt   = (pcnt == 19) ? 0 : pcnt + 1;
        pwm_in = pwm_en && (pcnt < 10);
    end

    function automatic logic [8:0] outs();
        return {fault, flt_field, flt_power, flt_frame, flt_zero,
                flt_startup, flt_index, mag_near, mag_far};
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] exp;
        logic       seen;
        wait_clk(4);
        // R12: reset state
        check("R12 reset", outs(), 9'b0);
        rst_n = 1'b1;
        pwm_en = 1'b1;
        wait_clk(30);
        check("R12 after reset", outs(), 9'b0);

        // R2 R3 R9 R10 R11: sweep magnet lines x incremental lines
        for (int pw = 1; pw >= 0; pw--) begin
            pwm_en = (pw == 1);
            wait_clk(TO + 30);
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 8; v++) begin
                    logic mi, md, a, b, i, fld, pwr, st, ix;
                    mi = m[1]; md = m[0]; a = v[2]; b = v[1]; i = v[0];
                    mag_inc_n = mi; mag_dec_n = md;
                    inc_a = a; inc_b = b; inc_idx = i;
                    wait_clk(QL + 6);
                    pwr = (pw == 0);
                    fld = !mi && !md && !pwr;
                    st  = a && b && i;
                    ix  = i && (a || b) && !st;
                    exp = {fld | pwr | st | ix, fld, pwr, 1'b0, 1'b0, st, ix,
                           !mi && md, mi && !md};
                    check(pw ? "R2 R3 R9 R10 R11 sweep" : "R4 R5 sweep no pulses",
                          outs(), exp);
                end
            end
        end
        mag_inc_n = 1'b1; mag_dec_n = 1'b1;
        inc_a = 1'b0; inc_b = 1'b0; inc_idx = 1'b0;

        // R4: pulses resume, timeout clears
        pwm_en = 1'b1;
        wait_clk(30);
        check("R4 pulses resume", outs(), 9'b0);

        // R1: glitch of QL-1 clocks is never reported
        seen = 1'b0;
        mag_inc_n = 1'b0; mag_dec_n = 1'b0;
        wait_clk(QL - 1);
        mag_inc_n = 1'b1; mag_dec_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            wait_clk(1);
            seen |= flt_field;
        end
        check("R1 short glitch", {8'b0, seen}, 9'b0);

        // R1: exactly QL clocks is reported
        seen = 1'b0;
        mag_inc_n = 1'b0; mag_dec_n = 1'b0;
        wait_clk(QL);
        mag_inc_n = 1'b1; mag_dec_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            wait_clk(1);
            seen |= flt_field;
        end
        check("R1 full-length glitch", {8'b0, seen}, 9'b1);
        check("R1 drops after release", outs(), 9'b0);

        // R6 R7 R8: frame sweep over all status words and three data words
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 3; d++) begin
                logic [DW-1:0] dv;
                logic fi, fz;
                dv = (d == 0) ? 8'h00 : (d == 1) ? 8'h01 : 8'h80;
                frm_clr = 1'b1; wait_clk(1); frm_clr = 1'b0;
                frm_stb = 1'b1; frm_data = dv; frm_stat = 4'(s);
                wait_clk(1);
                frm_stb = 1'b0;
                fi = !s[0];
                fz = (dv == 0) && (s == 0);
                check("R6 R7 R11 frame", outs(),
                      {fi | fz, 2'b00, fi, fz, 4'b0000});
            end
        end

        // R6: valid frame does not clear sticky flag
        frm_stb = 1'b1; frm_data = 8'h00; frm_stat = 4'h0; wait_clk(1);
        frm_data = 8'h55; frm_stat = 4'h1; wait_clk(1);
        frm_stb = 1'b0;
        check("R6 sticky", outs(), 9'b100110000);

        // R8: clear with a failing frame in the same clock keeps flt_frame
        frm_clr = 1'b1; frm_stb = 1'b1; frm_data = 8'h12; frm_stat = 4'h2;
        wait_clk(1);
        frm_clr = 1'b0; frm_stb = 1'b0;
        check("R8 clear vs new fail", outs(), 9'b100100000);

        // R8: clear with a valid frame clears both
        frm_clr = 1'b1; frm_stb = 1'b1; frm_stat = 4'h1;
        wait_clk(1);
        frm_clr = 1'b0; frm_stb = 1'b0;
        check("R8 clear", outs(), 9'b0);

        // R12: reset clears sticky flags
        frm_stb = 1'b1; frm_stat = 4'h0; frm_data = 8'h00; wait_clk(1);
        frm_stb = 1'b0;
        rst_n = 1'b0; wait_clk(2);
        check("R12 reset clears", outs(), 9'b0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule